// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a clocked, synthesizable stand-in for a word-organised static memory that has an asynchronous-style pin interface. Each word holds two 8-bit lanes. The surrounding logic drives the control pins, all active low: a select, a read-output enable, a write strobe and one enable per lane. A fast sampling clock takes the place of the pin timing. The block samples every pin on each rising edge and acts on what it sees.

Each lane has its own write window. The window is open while select, write strobe and that lane's enable are all low. Whichever of these rises first closes it. When a lane's window closes, the block stores the address and the lane data that were sampled on the last edge on which the window was still open.

Reads need no clock. The addressed word appears at once on every lane the decoder drives, and a lane that is not driven reads as zero. The block splits the bidirectional bus into data-in, data-out and a per-lane drive enable, so a pad ring or bench can build the tri-state pins. A mode code and a standby flag report the decoded state of the control pins.

The pins are plain levels with no valid/ready handshake. The control pins themselves define when a transfer happens, so the block never applies back-pressure and its outputs are never held off.

Top module: `sram_lane_model`

## Requirements
- R1: The block stores 2**ADDR_W words of LANES lanes of LANE_W bits. The defaults are 1024 words of 2 x 8 bits, and the full-size part uses ADDR_W=16. Every address keeps its own value, including address 0 and the last address.
- R2: The write window of lane i is open only while sel_n=0, wr_n=0 and lane_en_n[i]=0. A lane whose enable is high is never written. lane_en_n[0] governs data bits 7:0, and lane_en_n[1] governs bits 15:8.
- R3: A lane is written on the first rising edge at which its window is seen closed. The value and the address written are those sampled on the previous edge. Each lane closes on its own, whichever of sel_n, wr_n or its lane enable rises first.
- R4: data_oe[i] is 1 exactly when sel_n=0, out_en_n=0, wr_n=1 and lane_en_n[i]=0. A driven lane shows the stored lane of mem[addr] in the same cycle, with no clock in the path.
- R5: Both lanes are undriven (data_oe=00) and data_out reads zero in each of these cases: sel_n is high, out_en_n is high, both lane enables are high, or a write is in progress (sel_n=0 and wr_n=0).
- R6: standby is 1 exactly when sel_n=1. Every other pin combination is active.
- R7: mode uses this encoding: 0 = standby, 1 = selected with outputs off, 2 = read, 3 = write. The decoder takes the first match in this order: sel_n high gives 0; both lane enables high gives 1; wr_n low gives 3; out_en_n low gives 2; anything else gives 1.
- R8: Reset clears the window trackers. A window that is open when reset asserts and closes during reset writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the window trackers |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low read output enable |
| wr_n | input | 1 | Active-low write strobe |
| lane_en_n | input | LANES | Active-low per-lane enable, bit i for data bits of lane i |
| data_in | input | LANES*LANE_W | Data sampled from the bus |
| data_out | output | LANES*LANE_W | Read data, zero on undriven lanes |
| data_oe | output | LANES | Per-lane bus drive enable |
| mode | output | 2 | Decoded mode code |
| standby | output | 1 | High while deselected |

## Verification
The assertions check on every cycle that the decoded mode agrees with the lane drive enables. They confirm that no lane is driven while writing, deselected or with outputs off, that a read drives at least one lane, and that a committed lane really holds its data on the next edge. Other behaviours can only be shown by the bench's scenarios. These are that the value stored is the one from the cycle before the window closed, that lanes close independently, that an open window is discarded across reset, and that each address keeps its own contents. The bench checks them by reading back against its reference array.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OFF     = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_ctrl_dec.sv
module sram_ctrl_dec
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             out_en_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_en_n,
  output sram_mode_e       mode_o,
  output logic [LANES-1:0] lane_rd_o,
  output logic [LANES-1:0] lane_win_o
);

  logic any_lane;
  assign any_lane = ~&lane_en_n;

  // mode priority: deselect, no lane, write, read, outputs off
  always_comb begin
    if (sel_n)          mode_o = MODE_STANDBY;
    else if (!any_lane) mode_o = MODE_OFF;
    else if (!wr_n)     mode_o = MODE_WRITE;
    else if (!out_en_n) mode_o = MODE_READ;
    else                mode_o = MODE_OFF;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_rd_o[i]  = ~sel_n & ~out_en_n & wr_n & ~lane_en_n[i];
    assign lane_win_o[i] = ~sel_n & ~wr_n & ~lane_en_n[i];
  end

  p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_WRITE) |-> (lane_rd_o == '0));

  p_off_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_OFF) |-> (lane_rd_o == '0));

  p_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (mode_o == MODE_STANDBY && lane_rd_o == '0 && lane_win_o == '0));

  p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_READ) |-> (lane_rd_o != '0));

endmodule

// File: rtl/sram_wr_window.sv
module sram_wr_window #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANE_W-1:0] commit_data
);

  logic              win_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] din_q;

  // last-open-cycle capture; closing edge commits it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      win_q  <= win;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  assign commit      = win_q & ~win;
  assign commit_addr = addr_q;
  assign commit_data = din_q;

  p_commit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_n,
  input  logic                    out_en_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [LANES*LANE_W-1:0] data_in,
  output logic [LANES*LANE_W-1:0] data_out,
  output logic [LANES-1:0]        data_oe,
  output logic [1:0]              mode,
  output logic                    standby
);

  sram_mode_e       mode_d;
  logic [LANES-1:0] lane_win;

  sram_ctrl_dec #(.LANES(LANES)) i_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .out_en_n   (out_en_n),
    .wr_n       (wr_n),
    .lane_en_n  (lane_en_n),
    .mode_o     (mode_d),
    .lane_rd_o  (data_oe),
    .lane_win_o (lane_win)
  );

  assign mode    = mode_d;
  assign standby = (mode_d == MODE_STANDBY);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              cm;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANE_W-1:0] cm_data;
    logic [LANE_W-1:0] rd_lane;

    sram_wr_window #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .win         (lane_win[i]),
      .addr        (addr),
      .din         (data_in[i*LANE_W +: LANE_W]),
      .commit      (cm),
      .commit_addr (cm_addr),
      .commit_data (cm_data)
    );

    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cm),
      .wr_addr (cm_addr),
      .wr_data (cm_data),
      .rd_addr (addr),
      .rd_data (rd_lane)
    );

    assign data_out[i*LANE_W +: LANE_W] = data_oe[i] ? rd_lane : '0;
  end

endmodule

// File: tb/test_sram_lane_model.sv
module test_sram_lane_model;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_n, out_en_n, wr_n;
  logic [1:0]    lane_en_n;
  logic [15:0]   data_in;
  wire  [15:0]   data_out;
  wire  [1:0]    data_oe;
  wire  [1:0]    mode;
  wire           standby;

  logic [15:0] ref_mem [DEPTH];
  int n_cmp = 0;
  int n_bad = 0;

  sram_lane_model #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) i_sram_lane_model (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .out_en_n(out_en_n),
    .wr_n(wr_n), .lane_en_n(lane_en_n), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .mode(mode), .standby(standby)
  );

  function automatic logic [1:0] f_mode(logic s, logic o, logic w, logic [1:0] b);
    if (s) return 2'd0;
    if (b == 2'b11) return 2'd1;
    if (!w) return 2'd3;
    if (!o) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic [1:0] f_oe(logic s, logic o, logic w, logic [1:0] b);
    return {!s && !o && w && !b[1], !s && !o && w && !b[0]};
  endfunction

  function automatic logic [15:0] f_dout(logic [1:0] oe, logic [15:0] wd);
    return {oe[1] ? wd[15:8] : 8'h00, oe[0] ? wd[7:0] : 8'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // checks all outputs against the pins currently applied
  task automatic pins_check(input string req);
    logic [1:0] eo;
    eo = f_oe(sel_n, out_en_n, wr_n, lane_en_n);
    #1;
    chk({req, " mode R7"}, 32'(mode), 32'(f_mode(sel_n, out_en_n, wr_n, lane_en_n)));
    chk({req, " oe R4/R5"}, 32'(data_oe), 32'(eo));
    chk({req, " standby R6"}, 32'(standby), 32'(sel_n));
    chk({req, " data R4"}, 32'(data_out), 32'(f_dout(eo, ref_mem[addr])));
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] be, input int hold, input int closer,
                          input bit chk_en);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      addr = a; sel_n = 1'b0; wr_n = 1'b0; lane_en_n = be;
      out_en_n = 1'($urandom);
      data_in = (k == hold - 1) ? d : 16'($urandom);
      if (chk_en) pins_check("write window R2");
    end
    @(negedge clk);
    case (closer)
      0: sel_n = 1'b1;
      1: wr_n = 1'b1;
      default: lane_en_n = 2'b11;
    endcase
    addr = AW'($urandom);
    data_in = 16'($urandom);
    @(posedge clk);
    if (!be[0]) ref_mem[a][7:0] = d[7:0];
    if (!be[1]) ref_mem[a][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic o, input logic [1:0] be,
                         input string req);
    @(negedge clk);
    addr = a; sel_n = 1'b0; wr_n = 1'b1; out_en_n = o; lane_en_n = be;
    data_in = 16'($urandom);
    pins_check(req);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int seed;
    logic [15:0] d1, d2, keep;
    seed = $urandom(32'd5150);
    rst_n = 1'b0; addr = '0; sel_n = 1'b1; out_en_n = 1'b1; wr_n = 1'b1;
    lane_en_n = 2'b11; data_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pins_check("reset R6 R5");
    rst_n = 1'b1;

    // preload every word
    for (int a = 0; a < DEPTH; a++)
      do_write(AW'(a), 16'($urandom), 2'b00, 1, 1, 1'b0);

    // R1: extreme addresses hold distinct values
    do_write('0, 16'h1234, 2'b00, 1, 1, 1'b1);
    do_write(AW'(DEPTH - 1), 16'hFEDC, 2'b00, 1, 1, 1'b1);
    do_read('0, 1'b0, 2'b00, "R1 addr0");
    do_read(AW'(DEPTH - 1), 1'b0, 2'b00, "R1 addrmax");

    // nine truth-table modes at one address
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b0; out_en_n = 1'b0; lane_en_n = 2'b00;
    pins_check("R6 standby");
    do_read(AW'(7), 1'b0, 2'b00, "R4 read both");
    do_read(AW'(7), 1'b0, 2'b10, "R4 read low");
    do_read(AW'(7), 1'b0, 2'b01, "R4 read high");
    do_write(AW'(7), 16'hA5C3, 2'b00, 2, 1, 1'b1);
    do_write(AW'(7), 16'h0F11, 2'b10, 1, 0, 1'b1);
    do_write(AW'(7), 16'h77EE, 2'b01, 1, 2, 1'b1);
    do_read(AW'(7), 1'b0, 2'b00, "R2 lane merge");
    chk("R2 merged word", 32'(data_out), 32'h7711);
    do_read(AW'(7), 1'b1, 2'b00, "R5 outputs off");
    do_read(AW'(7), 1'b0, 2'b11, "R5 no lane");

    // R3: lanes close independently, each taking its prior-cycle data
    d1 = 16'h3C4B; d2 = 16'hD269;
    @(negedge clk); addr = AW'(9); sel_n = 1'b0; wr_n = 1'b0; lane_en_n = 2'b00; data_in = d1;
    @(negedge clk); lane_en_n = 2'b01; data_in = d2;
    @(negedge clk); lane_en_n = 2'b11; data_in = 16'hFFFF; addr = AW'(3);
    @(posedge clk);
    ref_mem[9] = {d2[15:8], d1[7:0]};
    do_read(AW'(9), 1'b0, 2'b00, "R3 staggered close");
    chk("R3 staggered word", 32'(data_out), 32'({d2[15:8], d1[7:0]}));

    // R8: window open across reset is discarded
    keep = ref_mem[11];
    @(negedge clk); addr = AW'(11); sel_n = 1'b0; wr_n = 1'b0; lane_en_n = 2'b00;
    data_in = ~keep;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; data_in = 16'($urandom);
    @(negedge clk); rst_n = 1'b1; sel_n = 1'b1;
    do_read(AW'(11), 1'b0, 2'b00, "R8 reset discard");
    chk("R8 word kept", 32'(data_out), 32'(keep));

    // constrained random mix
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom % 4);
      if (r == 0) begin
        do_write(AW'($urandom), 16'($urandom), 2'($urandom % 3),
                 1 + int'($urandom % 3), int'($urandom % 3), 1'b1);
      end else if (r < 3) begin
        do_read(AW'($urandom), 1'($urandom), 2'($urandom), "R4 random read");
      end else begin
        @(negedge clk);
        addr = AW'($urandom); sel_n = 1'($urandom); out_en_n = 1'($urandom);
        lane_en_n = 2'($urandom);
        wr_n = (!sel_n && lane_en_n != 2'b11) ? 1'b1 : 1'($urandom);
        pins_check("R5 random control");
      end
    end

    // final sweep of all contents
    for (int a = 0; a < DEPTH; a++)
      do_read(AW'(a), 1'b0, 2'b00, "R1 sweep");

    finish_run();
  end
endmodule